// File: doc/BRIEF.md
# Banked GPIO Register Block with Per-Pin Drive Mode

This block is a GPIO logical device behind a byte-wide register bus made of an address, write data, a write strobe and a combinational read data return. It holds a parameterised number of GPIO banks. Each bank owns a group of four adjacent registers: pin direction, output data, synchronised pin status and per-pin drive mode. From these it drives an output-enable and an output value to each pad and samples each pad input.

Every pin can be set up as push-pull or open-drain. In open-drain mode the pin only ever pulls low. It asserts output-enable when its data bit is 0 and releases the pad when the bit is 1. Banks are placed from the top of the address space downward, 16 bytes apart. A bank may hold fewer than eight pins. The missing bit positions behave as absent.

The block has no sequencing state machine. Its only states are the register contents, which are written in a single cycle, and the two-stage input synchroniser.

Top module: `gpio_multibank`

## Requirements
- R1: After reset every readable register of every bank reads 0. All pins are inputs with output data 0 in open-drain mode, and no pad_oe bit is set.
- R2: Bank b answers at base address 0xF0 - 0x10*b. Address bits [1:0] select the register: 0 is direction, 1 is output data, 2 is pin status, 3 is drive mode. Any other address reads 0, and a write to it changes nothing.
- R3: A direction bit of 1 makes the pin an output and a 0 makes it an input. An input pin never asserts pad_oe.
- R4: With drive-mode bit 0 (open-drain), an output pin asserts pad_oe only while its data bit is 0. Its pad_out is always 0.
- R5: With drive-mode bit 1 (push-pull), pad_oe equals the direction bit and pad_out equals the output data bit.
- R6: Reading the output data register returns the last value written, whatever the direction setting.
- R7: In a bank of N pins, register bits N..7 read 0 and ignore writes, and their pad_oe and pad_out stay 0. Pad bits of bank b sit at positions 8*b+i.
- R8: The pin status register returns each implemented pad input through two flip-flops, for output pins as well. A pad change is first visible after the second rising edge. Writes to this register have no effect.
- R9: A register write takes effect at the next rising clock edge. Reads reflect the current register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Combinational read data |
| pad_in | input | 8*NUM_BANKS | Pad input samples, 8 bits per bank |
| pad_oe | output | 8*NUM_BANKS | Pad output enables |
| pad_out | output | 8*NUM_BANKS | Pad output values |

## Verification
A write is applied on one falling edge and removed on the next. By then one rising edge has passed, so the bench updates its model and compares read data and pad outputs at that point. Read data is combinational, so each read is checked one time step after the address changes, within the same low clock phase. Pin status needs two rising edges. The bench changes pad_in on a falling edge, checks one edge later that the old value still reads back, and checks after the second edge that the new value does.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned TOP_NIBBLE = 15;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_DOUT = 2'd1,
        REG_STAT = 2'd2,
        REG_MODE = 2'd3
    } reg_sel_e;

    function automatic logic [REG_W-1:0] width_mask(input int unsigned w);
        logic [15:0] ones;
        ones = (16'd1 << w) - 16'd1;
        return ones[REG_W-1:0];
    endfunction

endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (q == $past(d, 2)))
        else $error("status not two stages behind pad");

endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  reg_sel_e         off,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [REG_W-1:0] pad_in,
    output logic [REG_W-1:0] pad_oe,
    output logic [REG_W-1:0] pad_out
);

    localparam logic [REG_W-1:0] MASK = width_mask(PINS);

    logic [REG_W-1:0] dir_q, dout_q, mode_q, stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            mode_q <= '0;
        end else if (hit && wr) begin
            unique case (off)
                REG_DIR:  dir_q  <= wdata & MASK;
                REG_DOUT: dout_q <= wdata & MASK;
                REG_STAT: ;
                REG_MODE: mode_q <= wdata & MASK;
            endcase
        end
    end

    gpio_mb_sync #(.W(REG_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in & MASK),
        .q     (stat_q)
    );

    always_comb begin
        unique case (off)
            REG_DIR:  rdata = dir_q;
            REG_DOUT: rdata = dout_q;
            REG_STAT: rdata = stat_q;
            REG_MODE: rdata = mode_q;
        endcase
    end

    // push-pull: enable follows direction; open-drain: enable only to pull low
    assign pad_oe  = dir_q & (mode_q | ~dout_q);
    assign pad_out = dout_q & mode_q;

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr && off == REG_DIR) |=> (dir_q == $past(wdata & MASK)))
        else $error("direction write did not land");

    p_stat_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr && off == REG_STAT) |=>
            ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)))
        else $error("status write disturbed a register");

    p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & ~mode_q) == '0))
        else $error("open-drain pin drove high");

    p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~dir_q) == '0))
        else $error("input pin driving");

    p_unimpl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_out | rdata) & ~MASK) == '0))
        else $error("unimplemented bit active");

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_mb_pkg::*;
#(
    parameter int unsigned               NUM_BANKS   = 3,
    parameter logic [NUM_BANKS*4-1:0]    BANK_WIDTHS = {4'd5, 4'd8, 4'd6}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    input  logic                       reg_wr,
    output logic [REG_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*REG_W-1:0] pad_in,
    output logic [NUM_BANKS*REG_W-1:0] pad_oe,
    output logic [NUM_BANKS*REG_W-1:0] pad_out
);

    reg_sel_e               off;
    logic [NUM_BANKS-1:0]   bank_hit;
    logic [REG_W-1:0]       bank_rd [NUM_BANKS];

    assign off = reg_sel_e'(reg_addr[1:0]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [3:0] HI = 4'(TOP_NIBBLE - b);

        assign bank_hit[b] = (reg_addr[7:4] == HI) && (reg_addr[3:2] == 2'b00);

        gpio_mb_bank #(.PINS(BANK_WIDTHS[b*4 +: 4])) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (bank_hit[b]),
            .off     (off),
            .wr      (reg_wr),
            .wdata   (reg_wdata),
            .rdata   (bank_rd[b]),
            .pad_in  (pad_in [b*REG_W +: REG_W]),
            .pad_oe  (pad_oe [b*REG_W +: REG_W]),
            .pad_out (pad_out[b*REG_W +: REG_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) reg_rdata = reg_rdata | bank_rd[b];
        end
    end

    p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit == '0) |-> (reg_rdata == '0))
        else $error("unmapped address returned data");

    p_single_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit))
        else $error("two banks decoded");

endmodule

// File: tb/sim_gpio_multibank.sv
module sim_gpio_multibank;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_rdata;
    logic [NB*8-1:0]   pad_in = '0;
    logic [NB*8-1:0]   pad_oe, pad_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0]      m_dir  [NB];
    logic [7:0]      m_dout [NB];
    logic [7:0]      m_mode [NB];
    logic [NB*8-1:0] m_pad;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_multibank #(.NUM_BANKS(NB), .BANK_WIDTHS({4'd5, 4'd8, 4'd6})) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [7:0] bank_mask(input int b);
        case (b)
            0: return 8'h3F;
            1: return 8'hFF;
            2: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int bank_of(input logic [7:0] a);
        int b;
        b = 15 - int'(a[7:4]);
        if (a[3:2] != 2'b00 || b >= NB) return -1;
        return b;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        int b;
        b = bank_of(a);
        if (b < 0) return 8'h00;
        case (a[1:0])
            2'd0: return m_dir[b];
            2'd1: return m_dout[b];
            2'd2: return m_pad[b*8 +: 8] & bank_mask(b);
            default: return m_mode[b];
        endcase
    endfunction

    function automatic logic [NB*8-1:0] exp_oe();
        logic [NB*8-1:0] r;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 8; i++)
                r[b*8+i] = m_dir[b][i] && (m_mode[b][i] || !m_dout[b][i]);
        return r;
    endfunction

    function automatic logic [NB*8-1:0] exp_out();
        logic [NB*8-1:0] r;
        for (int b = 0; b < NB; b++)
            r[b*8 +: 8] = m_mode[b] ? (m_dout[b] & m_mode[b]) : 8'h00;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        int b;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        b = bank_of(a);
        if (b >= 0) begin
            case (a[1:0])
                2'd0: m_dir[b]  = d & bank_mask(b);
                2'd1: m_dout[b] = d & bank_mask(b);
                2'd3: m_mode[b] = d & bank_mask(b);
                default: ;
            endcase
        end
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a);
        reg_addr = a;
        #1;
        chk(tag, {{(NB*8-8){1'b0}}, reg_rdata}, {{(NB*8-8){1'b0}}, exp_read(a)});
    endtask

    task automatic pad_chk(input string tag);
        chk({tag, " oe"},  pad_oe,  exp_oe());
        chk({tag, " out"}, pad_out, exp_out());
    endtask

    task automatic read_all(input string tag);
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < 4; o++)
                read_chk(tag, 8'(8'hF0 - 8'(16*b) + 8'(o)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        int b;
        void'($urandom(32'd20240611));
        for (int k = 0; k < NB; k++) begin
            m_dir[k] = '0; m_dout[k] = '0; m_mode[k] = '0;
        end
        m_pad = '0;
        pad_in = {8'hFF, 8'hA5, 8'h3C};
        repeat (3) @(negedge clk);
        // R1: reset state, pads held high but synchroniser still reset
        read_all("R1 reset read");
        pad_chk("R1 reset pads");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m_pad = pad_in;

        // R8: two-edge latency, also on output pins
        write_reg(8'hF0, 8'hFF);
        reg_addr = 8'hF2;
        pad_in[7:0] = 8'h15;
        @(negedge clk);
        read_chk("R8 one edge old", 8'hF2);
        @(negedge clk);
        m_pad = pad_in;
        read_chk("R8 two edges new", 8'hF2);
        write_reg(8'hF2, 8'h00);
        read_chk("R8 status write ignored", 8'hF2);
        read_all("R8 regs after status write");

        // R4: open-drain drives low only
        write_reg(8'hF1, 8'h55);
        pad_chk("R4 open drain");
        // R5: push-pull
        write_reg(8'hF3, 8'hFF);
        pad_chk("R5 push pull");
        // R3: back to input
        write_reg(8'hF0, 8'h00);
        pad_chk("R3 input no drive");
        // R6: output data readback with pin as input
        read_chk("R6 dout readback input", 8'hF1);

        // R7: narrow bank ignores upper bits
        write_reg(8'hD0, 8'hFF);
        write_reg(8'hD1, 8'hFF);
        write_reg(8'hD3, 8'hFF);
        read_chk("R7 narrow dir", 8'hD0);
        read_chk("R7 narrow mode", 8'hD3);
        pad_chk("R7 narrow pads");

        // R2: unmapped addresses
        write_reg(8'hF4, 8'hAA);
        write_reg(8'hEF, 8'hAA);
        write_reg(8'hC0, 8'hAA);
        read_chk("R2 miss F4", 8'hF4);
        read_chk("R2 miss C0", 8'hC0);
        read_all("R2 regs after misses");
        pad_chk("R2 pads after misses");

        // R9: write visible after one edge, read same cycle
        @(negedge clk);
        reg_addr = 8'hE1; reg_wdata = 8'h81; reg_wr = 1'b1;
        #1;
        chk("R9 before edge", {16'h0, reg_rdata}, {16'h0, exp_read(8'hE1)});
        @(negedge clk);
        reg_wr = 1'b0;
        m_dout[1] = 8'h81;
        read_chk("R9 after edge", 8'hE1);

        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom % 4 != 0) begin
                b = int'($urandom % NB);
                a = 8'(8'hF0 - 8'(16*b) + 8'($urandom % 4));
            end else begin
                a = 8'($urandom);
            end
            write_reg(a, 8'($urandom));
            if ($urandom % 8 == 0) begin
                pad_in = NB*8'($urandom);
                pad_in = {8'($urandom), 8'($urandom), 8'($urandom)};
                @(negedge clk);
                @(negedge clk);
                m_pad = pad_in;
            end
            read_chk("R2 R6 R7 random read", 8'($urandom));
            b = int'($urandom % NB);
            read_chk("R6 R8 random bank read", 8'(8'hF0 - 8'(16*b) + 8'($urandom % 4)));
            pad_chk("R3 R4 R5 random pads");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule